// File: doc/BRIEF.md
# Configuration Register Access Gate

This block sits between a request source and a small bank of per-device configuration registers. A request carries one packed 32-bit location word, an access width in bytes, and, for writes, a data word. It also carries the number of argument and result words the caller framed the call with. The gate unpacks a device selector and a 12-bit register offset from the location word. It then checks the access width, the framing counts, that the selected device is present, that the offset is naturally aligned, and that the offset lies inside that device's configuration space.

When every check passes, the gate performs the access on the selected device's registers. It answers with an all-zero status and, for a read, the data. When any check fails, the gate answers with an all-ones status, returns zero data, and does not modify any register. Each device states through its own input pins whether it is present and whether its configuration space is 256 or 4096 bytes.

The request and response sides use valid/ready handshakes. Only one response is outstanding at a time.

Top module: `cfg_access_gate`

## Requirements
- R1: The access width `req_size` must be 1, 2 or 4. Any other value, including 0, 3 and 8, gives the failure status.
- R2: The device selector is bits [15:8] of `req_addr`. The access fails unless the selector is below NUM_DEV and `dev_present` is set at that index. Each device has its own separate registers.
- R3: The register offset is `{req_addr[27:24], req_addr[7:0]}`. Bits [31:28] and [23:16] are ignored. An offset that is not a multiple of the width fails.
- R4: A device with `dev_ext` clear has a 256-byte space, so any offset of 256 or more fails. A device with `dev_ext` set accepts offsets up to 4095.
- R5: Success returns status 32'h0000_0000. Every failure returns status 32'hFFFF_FFFF. `rsp_data` holds the read value for a successful read and zero for writes and failures.
- R6: A read must be framed as 2 arguments with 2 results, or 4 arguments with 2 results. A write must be framed as 3 arguments with 1 result, or 5 arguments with 1 result. Any other framing fails.
- R7: A failed request leaves every stored register unchanged.
- R8: Byte lane numbering:
  - Storage words are 32 bits wide, and byte lane k is bits [8k+7:8k].
  - A write of width n at offset o replaces lanes o[1:0] through o[1:0]+n-1 with the low n bytes of `req_wdata`, and leaves the other lanes unchanged.
  - A read returns those lanes right-justified and zero-extended.
  - The word index is offset bits [2+log2(DEPTH)-1:2]. Higher offset bits fold onto the same words.
- R9: Handshake timing:
  - `req_ready` is high exactly when no response is pending.
  - `rsp_valid` rises in the cycle after a request is accepted.
  - The response stays valid and stable until a cycle with `rsp_ready` high.
- R10: After reset, `rsp_valid` is 0, `req_ready` is 1 and all registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_present | input | NUM_DEV | Per-device presence flag |
| dev_ext | input | NUM_DEV | Per-device 4096-byte space flag (0 = 256 bytes) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Packed location word |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 32 | Write data, low bytes used |
| req_nargs | input | 4 | Argument word count of the call |
| req_nret | input | 4 | Result word count of the call |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_status | output | 32 | 0 on success, all ones on failure |
| rsp_data | output | 32 | Read data or zero |

## Verification
The hardest case to observe from the ports is a rejected write. The target word is the same whether the write lands or not, so a rejection is invisible at the moment it happens. The stimulus therefore first stores a known pattern at the exact word the rejected write aims at. After each rejected write (bad width, misalignment, wrong framing, out-of-range offset), it reads that word back with a legal read. The extended offset is driven with garbage in the ignored address bits and with high offset nibbles. This shows that the upper nibble decides the range check while the word folding sends two different offsets to one word.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;

  localparam int OFF_W = 12;

  // Lane enables for an access of width sz starting at byte lane lo.
  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [3:0] sz);
    logic [3:0] base;
    case (sz)
      4'd1:    base = 4'b0001;
      4'd2:    base = 4'b0011;
      default: base = 4'b1111;
    endcase
    return base << lo;
  endfunction

  // Keep only the low sz bytes of a right-justified value.
  function automatic logic [31:0] width_trim(input logic [31:0] v, input logic [3:0] sz);
    case (sz)
      4'd1:    return {24'h0, v[7:0]};
      4'd2:    return {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
  import cfg_gate_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               is_write,
  input  logic [31:0]        addr_word,
  input  logic [3:0]         size,
  input  logic [3:0]         nargs,
  input  logic [3:0]         nret,
  input  logic [NUM_DEV-1:0] dev_present,
  input  logic [NUM_DEV-1:0] dev_ext,
  output logic               ok,
  output logic [DEV_W-1:0]   dev_idx,
  output logic [OFF_W-1:0]   offset
);

  logic [7:0]         sel;
  logic [NUM_DEV-1:0] hit;
  logic               dev_ok;
  logic               ext_hit;
  logic               size_ok;
  logic               align_ok;
  logic               bound_ok;
  logic               frame_ok;
  logic               unused_addr_bits;

  assign sel     = addr_word[15:8];
  assign offset  = {addr_word[27:24], addr_word[7:0]};
  assign dev_idx = sel[DEV_W-1:0];
  assign unused_addr_bits = ^{addr_word[31:28], addr_word[23:16]};

  // One comparator per device slot.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_DEV; gi++) begin : g_match
      assign hit[gi] = (sel == 8'(gi)) && dev_present[gi];
    end
  endgenerate

  assign dev_ok  = |hit;
  assign ext_hit = |(hit & dev_ext);

  always_comb begin
    size_ok  = (size == 4'd1) || (size == 4'd2) || (size == 4'd4);
    align_ok = (size == 4'd1)
            || ((size == 4'd2) && !offset[0])
            || ((size == 4'd4) && (offset[1:0] == 2'b00));
    bound_ok = ext_hit || (offset[11:8] == 4'h0);
    if (is_write) begin
      frame_ok = ((nargs == 4'd3) || (nargs == 4'd5)) && (nret == 4'd1);
    end else begin
      frame_ok = ((nargs == 4'd2) || (nargs == 4'd4)) && (nret == 4'd2);
    end
    ok = frame_ok && size_ok && dev_ok && align_ok && bound_ok;
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_gate_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEPTH   = 16,
  parameter int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  parameter int WIDX    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DEV_W-1:0] dev_idx,
  input  logic [OFF_W-1:0] offset,
  input  logic [3:0]       size,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] mem_q   [NUM_DEV][DEPTH];
  logic [31:0] mem_nxt [NUM_DEV][DEPTH];

  logic [WIDX-1:0] word_idx;
  logic [1:0]      lo;
  logic [3:0]      mask;
  logic [31:0]     cur_word;
  logic [31:0]     wshift;
  logic [31:0]     merged;
  logic            unused_off_bits;

  assign word_idx = offset[2 +: WIDX];
  assign lo       = offset[1:0];
  assign mask     = lane_mask(lo, size);
  assign cur_word = mem_q[dev_idx][word_idx];
  assign wshift   = wdata << {lo, 3'b000};
  assign unused_off_bits = ^offset;

  // Byte-lane merge of the write data into the addressed word.
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      merged[b*8 +: 8] = mask[b] ? wshift[b*8 +: 8] : cur_word[b*8 +: 8];
    end
  end

  assign rdata = width_trim(cur_word >> {lo, 3'b000}, size);

  always_comb begin
    mem_nxt = mem_q;
    if (we) begin
      mem_nxt[dev_idx][word_idx] = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        for (int w = 0; w < DEPTH; w++) begin
          mem_q[d][w] <= '0;
        end
      end
    end else if (we) begin
      mem_q <= mem_nxt;
    end
  end

  AST_LANES_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (({2'b00, lo} + size) <= 4'd4)); // R3

  AST_WRITE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(mask) == int'(size))); // R1

endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
  import cfg_gate_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEPTH   = 16,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int WIDX   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] dev_present,
  input  logic [NUM_DEV-1:0] dev_ext,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [31:0]        req_addr,
  input  logic [3:0]         req_size,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_nargs,
  input  logic [3:0]         req_nret,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_status,
  output logic [31:0]        rsp_data
);

  logic             dec_ok;
  logic [DEV_W-1:0] dec_dev;
  logic [OFF_W-1:0] dec_off;
  logic [31:0]      bank_rdata;
  logic             accept;
  logic             bank_we;

  logic             vld_q, vld_nxt;
  logic [31:0]      st_q, st_nxt;
  logic [31:0]      dat_q, dat_nxt;
  logic             rsp_en;

  cfg_req_check #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) i_check (
    .is_write    (req_write),
    .addr_word   (req_addr),
    .size        (req_size),
    .nargs       (req_nargs),
    .nret        (req_nret),
    .dev_present (dev_present),
    .dev_ext     (dev_ext),
    .ok          (dec_ok),
    .dev_idx     (dec_dev),
    .offset      (dec_off)
  );

  assign req_ready = !vld_q;
  assign accept    = req_valid && req_ready;
  assign bank_we   = accept && req_write && dec_ok;

  cfg_reg_bank #(.NUM_DEV(NUM_DEV), .DEPTH(DEPTH), .DEV_W(DEV_W), .WIDX(WIDX)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bank_we),
    .dev_idx (dec_dev),
    .offset  (dec_off),
    .size    (req_size),
    .wdata   (req_wdata),
    .rdata   (bank_rdata)
  );

  // Response next-state.
  always_comb begin
    vld_nxt = vld_q;
    st_nxt  = st_q;
    dat_nxt = dat_q;
    rsp_en  = 1'b0;
    if (accept) begin
      rsp_en  = 1'b1;
      vld_nxt = 1'b1;
      st_nxt  = dec_ok ? ST_OK : ST_FAIL;
      dat_nxt = (dec_ok && !req_write) ? bank_rdata : 32'h0;
    end else if (vld_q && rsp_ready) begin
      rsp_en  = 1'b1;
      vld_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      st_q  <= ST_OK;
      dat_q <= '0;
    end else if (rsp_en) begin
      vld_q <= vld_nxt;
      st_q  <= st_nxt;
      dat_q <= dat_nxt;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_status = st_q;
  assign rsp_data   = dat_q;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_data))); // R9

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_status == ST_OK) || (rsp_status == ST_FAIL))); // R5

  AST_FAIL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == ST_FAIL)) |-> (rsp_data == 32'h0)); // R5

  AST_NO_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (req_size != 4'd1) && (req_size != 4'd2)
     && (req_size != 4'd4)) |-> !bank_we); // R7

endmodule

// File: tb/test_cfg_access_gate.sv
`timescale 1ns/1ps
module test_cfg_access_gate;

  localparam logic [31:0] OK   = 32'h0000_0000;
  localparam logic [31:0] FAIL = 32'hFFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic [3:0]  dev_present;
  logic [3:0]  dev_ext;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic [31:0] req_wdata;
  logic [3:0]  req_nargs;
  logic [3:0]  req_nret;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_status;
  logic [31:0] rsp_data;

  int checks;
  int errors;
  bit finished;

  cfg_access_gate #(.NUM_DEV(4), .DEPTH(16)) i_cfg_access_gate (
    .clk(clk), .rst_n(rst_n), .dev_present(dev_present), .dev_ext(dev_ext),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_nargs(req_nargs), .req_nret(req_nret), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check32(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One full request/response exchange; returns status and data.
  task automatic issue(input logic w, input logic [31:0] a, input logic [3:0] sz,
                       input logic [31:0] wd, input logic [3:0] na, input logic [3:0] nr,
                       output logic [31:0] st, output logic [31:0] d);
    @(negedge clk);
    req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    req_nargs = na; req_nret = nr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check32("R9", "rsp_valid after accept", {31'h0, rsp_valid}, 32'h1);
    st = rsp_status;
    d  = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic wr_f(input string req, input logic [31:0] a, input logic [3:0] sz,
                      input logic [31:0] wd, input logic [3:0] na, input logic [3:0] nr,
                      input logic [31:0] exp_st);
    logic [31:0] st, d;
    issue(1'b1, a, sz, wd, na, nr, st, d);
    check32(req, "write status", st, exp_st);
    check32(req, "write data", d, 32'h0);
  endtask

  task automatic rd_f(input string req, input logic [31:0] a, input logic [3:0] sz,
                      input logic [3:0] na, input logic [3:0] nr,
                      input logic [31:0] exp_st, input logic [31:0] exp_d);
    logic [31:0] st, d;
    issue(1'b0, a, sz, 32'h0, na, nr, st, d);
    check32(req, "read status", st, exp_st);
    check32(req, "read data", d, exp_d);
  endtask

  task automatic wr(input string req, input logic [31:0] a, input logic [3:0] sz,
                    input logic [31:0] wd, input logic [31:0] exp_st);
    wr_f(req, a, sz, wd, 4'd3, 4'd1, exp_st);
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic [3:0] sz,
                    input logic [31:0] exp_st, input logic [31:0] exp_d);
    rd_f(req, a, sz, 4'd2, 4'd2, exp_st, exp_d);
  endtask

  task automatic t_reset;
    check32("R10", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check32("R10", "req_ready", {31'h0, req_ready}, 32'h1);
    rd("R10", 32'h0000_0010, 4'd4, OK, 32'h0);
  endtask

  task automatic t_word;
    wr("R5", 32'h0000_0010, 4'd4, 32'hA1B2_C3D4, OK);
    rd("R5", 32'h0000_0010, 4'd4, OK, 32'hA1B2_C3D4);
  endtask

  task automatic t_lanes;
    rd("R8", 32'h0000_0011, 4'd1, OK, 32'h0000_00C3);
    rd("R8", 32'h0000_0012, 4'd2, OK, 32'h0000_A1B2);
    rd("R8", 32'h0000_0010, 4'd1, OK, 32'h0000_00D4);
    wr("R8", 32'h0000_0013, 4'd1, 32'h0000_005A, OK);
    rd("R8", 32'h0000_0010, 4'd4, OK, 32'h5AB2_C3D4);
    wr("R8", 32'h0000_0010, 4'd2, 32'hFFFF_1234, OK);
    rd("R8", 32'h0000_0010, 4'd4, OK, 32'h5AB2_1234);
  endtask

  task automatic t_bad_size;
    wr("R1", 32'h0000_0010, 4'd3, 32'h0, FAIL);
    rd("R1", 32'h0000_0010, 4'd0, FAIL, 32'h0);
    rd("R1", 32'h0000_0010, 4'd8, FAIL, 32'h0);
    rd("R7", 32'h0000_0010, 4'd4, OK, 32'h5AB2_1234);
  endtask

  task automatic t_misalign;
    wr("R3", 32'h0000_0012, 4'd4, 32'h0, FAIL);
    wr("R3", 32'h0000_0011, 4'd2, 32'h0, FAIL);
    rd("R3", 32'h0000_0013, 4'd2, FAIL, 32'h0);
    rd("R7", 32'h0000_0010, 4'd4, OK, 32'h5AB2_1234);
  endtask

  task automatic t_framing;
    wr_f("R6", 32'h0000_0010, 4'd4, 32'h0, 4'd3, 4'd2, FAIL);
    rd("R7", 32'h0000_0010, 4'd4, OK, 32'h5AB2_1234);
    wr_f("R6", 32'h0000_0010, 4'd4, 32'h0102_0304, 4'd5, 4'd1, OK);
    rd_f("R6", 32'h0000_0010, 4'd4, 4'd4, 4'd2, OK, 32'h0102_0304);
    rd_f("R6", 32'h0000_0010, 4'd4, 4'd3, 4'd2, FAIL, 32'h0);
    rd_f("R6", 32'h0000_0010, 4'd4, 4'd2, 4'd1, FAIL, 32'h0);
  endtask

  task automatic t_devices;
    wr("R2", 32'h0000_0210, 4'd4, 32'hDEAD_BEEF, OK);
    rd("R2", 32'h0000_0010, 4'd4, OK, 32'h0102_0304);
    rd("R2", 32'h0000_0210, 4'd4, OK, 32'hDEAD_BEEF);
    wr("R2", 32'h0000_0310, 4'd4, 32'h1, FAIL);
    rd("R2", 32'h0000_8010, 4'd4, FAIL, 32'h0);
  endtask

  task automatic t_bounds;
    wr("R4", 32'h0100_0010, 4'd4, 32'h9999_9999, FAIL);
    rd("R7", 32'h0000_0010, 4'd4, OK, 32'h0102_0304);
    wr("R4", 32'h0000_00FC, 4'd4, 32'h1111_2222, OK);
    rd("R4", 32'h0000_00FC, 4'd4, OK, 32'h1111_2222);
    wr("R4", 32'h0F00_01FC, 4'd4, 32'h3333_4444, OK);
    rd("R4", 32'h0F00_01FC, 4'd4, OK, 32'h3333_4444);
    rd("R8", 32'h0000_013C, 4'd4, OK, 32'h3333_4444);
    rd("R3", 32'hF0AB_0110, 4'd4, OK, 32'h0);
    wr("R3", 32'hF0AB_0110, 4'd4, 32'h0000_0077, OK);
    rd("R3", 32'h0000_0110, 4'd4, OK, 32'h0000_0077);
  endtask

  task automatic t_hold;
    logic [31:0] st0, d0;
    @(negedge clk);
    req_write = 1'b0; req_addr = 32'h0000_0210; req_size = 4'd4;
    req_wdata = 32'h0; req_nargs = 4'd2; req_nret = 4'd2; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h0000_0010;
    st0 = rsp_status;
    d0  = rsp_data;
    check32("R9", "first response data", d0, 32'hDEAD_BEEF);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check32("R9", "held valid", {31'h0, rsp_valid}, 32'h1);
      check32("R9", "ready low while pending", {31'h0, req_ready}, 32'h0);
      check32("R9", "held data", rsp_data, d0);
      check32("R9", "held status", rsp_status, st0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check32("R9", "valid drops", {31'h0, rsp_valid}, 32'h0);
    check32("R9", "ready returns", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0;
    dev_present = 4'b0111;
    dev_ext = 4'b0010;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; req_nargs = '0; req_nret = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_lanes();
    t_bad_size();
    t_misalign();
    t_framing();
    t_devices();
    t_bounds();
    t_hold();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule